// File: doc/BRIEF.md
# Configuration Port Access Translator

This block sits between a processor-side I/O request port and a system bus master port. When translation is switched on, software's indirect configuration accesses become explicit memory-style bus commands. A write to the configuration address port is captured in a local register and completes without any bus traffic. A read or write of the configuration data port is re-issued as a single read or write command. The address of that command is the captured value's low 24 bits, placed inside a fixed 16-MB window whose upper bits are a module parameter. The byte enables decide between a byte-granular command and a full-longword command.

When translation is switched off, the two ports lose their special meaning and every I/O access goes to the bus unchanged as a plain I/O command. In both modes, interrupt-acknowledge reads are rebuilt so that the requester's 4-bit controller ID sits in address bits [15:12]. When the read data for such a read comes back, a one-cycle flush request for the posted write buffers is raised.

Only one generated transaction is in flight at any time. The I/O port is stalled through its ready signal until the bus response has been returned to the requester.

Top module: `cfgx_port_xlator`

## Requirements
- R1: After synchronous reset, io_ready is 1 and bus_valid, io_rsp_valid and flush_req are 0. The held configuration address is zero, so the first data-port access goes to window offset 0.
- R2: With mode_translate=1, an I/O write to port 0x0CF8 stores bits [23:0] of its data. It gives io_rsp_valid=1 (data 0) in the cycle after acceptance and starts no bus transaction.
- R3: With mode_translate=1, an I/O access to port 0x0CFC starts exactly one bus transaction. Its bus_addr is {WIN_BASE, low 24 bits of the most recent 0x0CF8 write}, with WIN_BASE in bus_addr[31:24].
- R4: The bus_cmd encoding is 0 I/O read, 1 I/O write, 2 byte read, 3 longword read, 4 byte write, 5 longword write, 6 interrupt acknowledge. A translated access with io_be=4'hF uses the longword command, and any other io_be value uses the byte command. bus_be equals io_be.
- R5: For a generated write, bus_wdata equals io_wdata and the response carries data 0. For a read, bus_wdata is 0 and io_rsp_rdata equals bus_rsp_rdata. io_rsp_valid pulses for one cycle, one cycle after bus_rsp_valid.
- R6: With mode_translate=0, accesses to 0x0CF8 and 0x0CFC are forwarded as I/O commands (0 or 1) with bus_addr equal to io_addr zero-extended. The held configuration address is left unchanged.
- R7: In either mode, an access to any other I/O address is forwarded as an I/O command with the address zero-extended. It does not change the held configuration address.
- R8: A read with io_iack=1 is issued as command 6 with bus_addr = {16'h0, io_id, io_addr[11:0]}, whatever the mode and port.
- R9: flush_req is 1 for exactly the one cycle in which the response to an interrupt-acknowledge read is presented, and is 0 at all other times.
- R10: From acceptance of a request until its response cycle, io_ready is 0. While bus_valid=1 and bus_ready=0, bus_valid, bus_cmd and bus_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_translate | input | 1 | 1 = translate configuration ports, 0 = forward them |
| io_valid | input | 1 | I/O request present |
| io_ready | output | 1 | Block can accept an I/O request |
| io_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_iack | input | 1 | Read targets interrupt-acknowledge space |
| io_addr | input | 16 | I/O port address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | I/O write data |
| io_id | input | 4 | Requester interrupt-controller ID |
| io_rsp_valid | output | 1 | I/O access completed |
| io_rsp_rdata | output | 32 | Read data for the completed access |
| bus_valid | output | 1 | Bus command present |
| bus_ready | input | 1 | Bus accepts the command |
| bus_cmd | output | 3 | Command code |
| bus_addr | output | 32 | Bus address |
| bus_be | output | 4 | Bus byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rsp_valid | input | 1 | Bus response present |
| bus_rsp_rdata | input | 32 | Bus response data |
| flush_req | output | 1 | Posted write buffer flush pulse |

## Verification
A corrupted held configuration address stays invisible until the next data-port access. That access then shows it at once on bus_addr, in the first cycle bus_valid rises, so every sweep follows each address-port write with a data-port read. A wrong class decode shows on bus_cmd or as an unexpected bus_valid one cycle after acceptance. A lost busy state shows as io_ready rising while a bus command is still pending, and a stale acknowledge flag shows as flush_req in a later, unrelated response cycle.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int IO_AW   = 16;
    localparam int BUS_AW  = 32;
    localparam int DW      = 32;
    localparam int BE_W    = DW / 8;
    localparam int ID_W    = 4;
    localparam int CFG_AW  = 24;
    localparam int WIN_W   = BUS_AW - CFG_AW;
    localparam int ID_LSB  = IO_AW - ID_W;

    typedef enum logic [2:0] {
        CMD_IO_RD    = 3'd0,
        CMD_IO_WR    = 3'd1,
        CMD_RD_BYTES = 3'd2,
        CMD_RD_LW    = 3'd3,
        CMD_WR_BYTES = 3'd4,
        CMD_WR_LW    = 3'd5,
        CMD_IACK     = 3'd6
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CLS_FWD,
        CLS_ADDR_WR,
        CLS_DATA,
        CLS_IACK
    } acc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } xl_state_e;

    typedef struct packed {
        logic              write;
        logic [IO_AW-1:0]  addr;
        logic [BE_W-1:0]   be;
        logic [DW-1:0]     wdata;
        logic [ID_W-1:0]   id;
    } io_req_t;

    typedef struct packed {
        bus_cmd_e          cmd;
        logic [BUS_AW-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DW-1:0]     wdata;
    } bus_req_t;

    function automatic logic all_bytes(input logic [BE_W-1:0] be);
        return &be;
    endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic             translate,
    input  logic             write,
    input  logic             iack,
    input  logic [IO_AW-1:0] addr,
    output acc_class_e       cls
);

    always_comb begin
        if (iack && !write)
            cls = CLS_IACK;
        else if (translate && write && addr == ADDR_PORT)
            cls = CLS_ADDR_WR;
        else if (translate && addr == DATA_PORT)
            cls = CLS_DATA;
        else
            cls = CLS_FWD;
    end

endmodule

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CFG_AW-1:0] din,
    output logic [CFG_AW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
    end

endmodule

// File: rtl/cfgx_cmd_build.sv
module cfgx_cmd_build
    import cfgx_pkg::*;
#(
    parameter logic [WIN_W-1:0] WIN_BASE = 8'hFE
) (
    input  acc_class_e        cls,
    input  io_req_t           req,
    input  logic [CFG_AW-1:0] cfg_addr,
    output bus_req_t          cmd
);

    localparam int PAD_W = BUS_AW - IO_AW;

    always_comb begin
        cmd.be    = req.be;
        cmd.wdata = req.write ? req.wdata : '0;
        unique case (cls)
            CLS_DATA: begin
                cmd.addr = {WIN_BASE, cfg_addr};
                if (req.write)
                    cmd.cmd = all_bytes(req.be) ? CMD_WR_LW : CMD_WR_BYTES;
                else
                    cmd.cmd = all_bytes(req.be) ? CMD_RD_LW : CMD_RD_BYTES;
            end
            CLS_IACK: begin
                cmd.cmd  = CMD_IACK;
                cmd.addr = {{PAD_W{1'b0}}, req.id, req.addr[ID_LSB-1:0]};
            end
            default: begin
                cmd.cmd  = req.write ? CMD_IO_WR : CMD_IO_RD;
                cmd.addr = {{PAD_W{1'b0}}, req.addr};
            end
        endcase
    end

endmodule

// File: rtl/cfgx_port_xlator.sv
module cfgx_port_xlator
    import cfgx_pkg::*;
#(
    parameter logic [WIN_W-1:0] WIN_BASE  = 8'hFE,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_translate,
    input  logic              io_valid,
    output logic              io_ready,
    input  logic              io_write,
    input  logic              io_iack,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BE_W-1:0]   io_be,
    input  logic [DW-1:0]     io_wdata,
    input  logic [ID_W-1:0]   io_id,
    output logic              io_rsp_valid,
    output logic [DW-1:0]     io_rsp_rdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [2:0]        bus_cmd,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_rsp_valid,
    input  logic [DW-1:0]     bus_rsp_rdata,
    output logic              flush_req
);

    xl_state_e         state_q;
    acc_class_e        cls;
    io_req_t           req;
    bus_req_t          built;
    bus_req_t          bus_q;
    logic [CFG_AW-1:0] cfg_addr;
    logic              accept;
    logic              iack_q;
    logic              wr_q;
    logic              rsp_valid_q;
    logic [DW-1:0]     rsp_data_q;
    logic              flush_q;

    assign req.write = io_write;
    assign req.addr  = io_addr;
    assign req.be    = io_be;
    assign req.wdata = io_wdata;
    assign req.id    = io_id;

    assign io_ready = (state_q == ST_IDLE);
    assign accept   = io_valid && io_ready;

    cfgx_decode #(
        .ADDR_PORT(ADDR_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_decode (
        .translate(mode_translate),
        .write    (io_write),
        .iack     (io_iack),
        .addr     (io_addr),
        .cls      (cls)
    );

    cfgx_addr_reg u_addr_reg (
        .clk (clk),
        .rst (rst),
        .load(accept && cls == CLS_ADDR_WR),
        .din (io_wdata[CFG_AW-1:0]),
        .q   (cfg_addr)
    );

    cfgx_cmd_build #(
        .WIN_BASE(WIN_BASE)
    ) u_build (
        .cls     (cls),
        .req     (req),
        .cfg_addr(cfg_addr),
        .cmd     (built)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            bus_q       <= '0;
            iack_q      <= 1'b0;
            wr_q        <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            flush_q     <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            flush_q     <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (cls == CLS_ADDR_WR) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= '0;
                        end else begin
                            bus_q   <= built;
                            iack_q  <= (cls == CLS_IACK);
                            wr_q    <= io_write;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (bus_ready)
                        state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (bus_rsp_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= wr_q ? '0 : bus_rsp_rdata;
                        flush_q     <= iack_q;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_valid    = (state_q == ST_ISSUE);
    assign bus_cmd      = bus_q.cmd;
    assign bus_addr     = bus_q.addr;
    assign bus_be       = bus_q.be;
    assign bus_wdata    = bus_q.wdata;
    assign io_rsp_valid = rsp_valid_q;
    assign io_rsp_rdata = rsp_data_q;
    assign flush_req    = flush_q;

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker
    import cfgx_pkg::*;
#(
    parameter logic [WIN_W-1:0] WIN_BASE  = 8'hFE,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_translate,
    input logic              io_valid,
    input logic              io_ready,
    input logic              io_write,
    input logic              io_iack,
    input logic [IO_AW-1:0]  io_addr,
    input logic              io_rsp_valid,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [2:0]        bus_cmd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              flush_req
);

    a_r2_addr_port_local: assert property (@(posedge clk) disable iff (rst)
        (io_valid && io_ready && mode_translate && io_write && !io_iack
         && io_addr == ADDR_PORT) |=> (io_rsp_valid && !bus_valid));

    a_r3_window_base: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_cmd inside {3'd2, 3'd3, 3'd4, 3'd5})
        |-> (bus_addr[BUS_AW-1:CFG_AW] == WIN_BASE));

    a_r9_flush_with_rsp: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> io_rsp_valid);

    a_r9_flush_single: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !io_ready);

    a_r10_hold_cmd: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_cmd) && $stable(bus_addr)));

endmodule

bind cfgx_port_xlator cfgx_checker #(
    .WIN_BASE (WIN_BASE),
    .ADDR_PORT(ADDR_PORT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_translate(mode_translate),
    .io_valid      (io_valid),
    .io_ready      (io_ready),
    .io_write      (io_write),
    .io_iack       (io_iack),
    .io_addr       (io_addr),
    .io_rsp_valid  (io_rsp_valid),
    .bus_valid     (bus_valid),
    .bus_ready     (bus_ready),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .flush_req     (flush_req)
);

// File: tb/cfgx_port_xlator_test.sv
module cfgx_port_xlator_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] WBASE = 8'hFE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_translate = 1'b1;
    logic        io_valid = 1'b0;
    logic        io_ready;
    logic        io_write = 1'b0;
    logic        io_iack = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic [3:0]  io_id = '0;
    logic        io_rsp_valid;
    logic [31:0] io_rsp_rdata;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [2:0]  bus_cmd;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;
    logic        flush_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [23:0] cfg_model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgx_port_xlator #(.WIN_BASE(WBASE)) uut (
        .clk(clk), .rst(rst), .mode_translate(mode_translate),
        .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write),
        .io_iack(io_iack), .io_addr(io_addr), .io_be(io_be),
        .io_wdata(io_wdata), .io_id(io_id),
        .io_rsp_valid(io_rsp_valid), .io_rsp_rdata(io_rsp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
        .flush_req(flush_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One I/O access with a bus model; exp_bus=0 means local completion
    task automatic access(input bit wr, input bit iack, input logic [15:0] addr,
                          input logic [3:0] be, input logic [31:0] wd,
                          input logic [3:0] id, input bit exp_bus,
                          input logic [2:0] ecmd, input logic [31:0] eaddr,
                          input logic [31:0] ret, input string req);
        @(negedge clk);
        chk(io_ready == 1'b1, {req, " ready before request (R10)"}, 32'(io_ready), 1);
        io_valid = 1'b1; io_write = wr; io_iack = iack; io_addr = addr;
        io_be = be; io_wdata = wd; io_id = id;
        @(negedge clk);
        io_valid = 1'b0;
        if (!exp_bus) begin
            chk(bus_valid == 1'b0, {req, " no bus command"}, 32'(bus_valid), 0);
            chk(io_rsp_valid == 1'b1, {req, " local response"}, 32'(io_rsp_valid), 1);
            chk(io_rsp_rdata == 32'h0, {req, " local response data"}, io_rsp_rdata, 0);
            chk(flush_req == 1'b0, {req, " no flush (R9)"}, 32'(flush_req), 0);
            return;
        end
        chk(bus_valid == 1'b1, {req, " bus_valid"}, 32'(bus_valid), 1);
        chk(bus_cmd == ecmd, {req, " bus_cmd (R4)"}, 32'(bus_cmd), 32'(ecmd));
        chk(bus_addr == eaddr, {req, " bus_addr"}, bus_addr, eaddr);
        chk(bus_be == be, {req, " bus_be (R4)"}, 32'(bus_be), 32'(be));
        chk(bus_wdata == (wr ? wd : 32'h0), {req, " bus_wdata (R5)"}, bus_wdata,
            wr ? wd : 32'h0);
        chk(io_ready == 1'b0, {req, " stalled while pending (R10)"}, 32'(io_ready), 0);
        @(negedge clk);
        chk(bus_valid == 1'b1 && bus_addr == eaddr && bus_cmd == ecmd,
            {req, " command held without ready (R10)"}, bus_addr, eaddr);
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(bus_valid == 1'b0, {req, " single command (R3)"}, 32'(bus_valid), 0);
        chk(io_ready == 1'b0 && io_rsp_valid == 1'b0,
            {req, " still stalled awaiting response (R10)"}, 32'(io_ready), 0);
        bus_rsp_valid = 1'b1; bus_rsp_rdata = ret;
        @(negedge clk);
        bus_rsp_valid = 1'b0; bus_rsp_rdata = 32'h0;
        chk(io_rsp_valid == 1'b1, {req, " response valid (R5)"}, 32'(io_rsp_valid), 1);
        chk(io_rsp_rdata == (wr ? 32'h0 : ret), {req, " response data (R5)"},
            io_rsp_rdata, wr ? 32'h0 : ret);
        chk(flush_req == iack, {req, " flush with response (R9)"}, 32'(flush_req),
            32'(iack));
        chk(io_ready == 1'b1, {req, " ready after response (R10)"}, 32'(io_ready), 1);
        @(negedge clk);
        chk(io_rsp_valid == 1'b0 && flush_req == 1'b0, {req, " one-cycle pulses (R5 R9)"},
            32'(io_rsp_valid), 0);
    endtask

    function automatic logic [2:0] xcmd(input bit wr, input logic [3:0] be);
        if (wr) return (be == 4'hF) ? 3'd5 : 3'd4;
        return (be == 4'hF) ? 3'd3 : 3'd2;
    endfunction

    task automatic set_cfg(input logic [31:0] v);
        access(1'b1, 1'b0, 16'h0CF8, 4'hF, v, 4'h0, 1'b0, 3'd0, 32'h0, 32'h0,
               "R2 addr port write");
        cfg_model = v[23:0];
    endtask

    task automatic cfg_read(input string req, input logic [31:0] ret);
        access(1'b0, 1'b0, 16'h0CFC, 4'hF, 32'h0, 4'h0, 1'b1, 3'd3,
               {WBASE, cfg_model}, ret, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(io_ready == 1'b1, "R1 reset io_ready", 32'(io_ready), 1);
        chk(bus_valid == 1'b0, "R1 reset bus_valid", 32'(bus_valid), 0);
        chk(io_rsp_valid == 1'b0, "R1 reset io_rsp_valid", 32'(io_rsp_valid), 0);
        chk(flush_req == 1'b0, "R1 reset flush_req", 32'(flush_req), 0);
        cfg_read("R1 zero config address", 32'h1111_2222);

        // R2/R3: captured address feeds the window
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            v = (32'h9E37_79B9 * (i + 1)) ^ (32'h1 << (i * 3));
            set_cfg(v);
            cfg_read("R3 window address", v + 32'h5);
        end
        // back-to-back address writes: only the latest counts
        set_cfg(32'hAAAA_0001);
        set_cfg(32'h5512_3456);
        cfg_read("R3 most recent address", 32'hCAFE_F00D);

        // R4/R5: every byte-enable pattern, both directions
        for (int b = 0; b < 16; b++) begin
            logic [31:0] d;
            d = 32'h0101_0101 * (b + 3);
            access(1'b1, 1'b0, 16'h0CFC, 4'(b), d, 4'h0, 1'b1, xcmd(1'b1, 4'(b)),
                   {WBASE, cfg_model}, 32'hDEAD_BEEF, "R4 R5 data write");
            access(1'b0, 1'b0, 16'h0CFC, 4'(b), 32'h0, 4'h0, 1'b1, xcmd(1'b0, 4'(b)),
                   {WBASE, cfg_model}, ~d, "R4 R5 data read");
        end

        // R6: forwarding mode leaves the held address untouched
        @(negedge clk) mode_translate = 1'b0;
        access(1'b1, 1'b0, 16'h0CF8, 4'hF, 32'h00FF_EE00, 4'h0, 1'b1, 3'd1,
               32'h0000_0CF8, 32'h0, "R6 forwarded addr write");
        access(1'b0, 1'b0, 16'h0CFC, 4'h3, 32'h0, 4'h0, 1'b1, 3'd0,
               32'h0000_0CFC, 32'h7777_0000, "R6 forwarded data read");
        access(1'b1, 1'b0, 16'h0CFC, 4'hF, 32'h1234_5678, 4'h0, 1'b1, 3'd1,
               32'h0000_0CFC, 32'h0, "R6 forwarded data write");
        @(negedge clk) mode_translate = 1'b1;
        cfg_read("R6 held address unchanged", 32'h0BAD_CAFE);

        // R7: other ports in both modes
        for (int m = 0; m < 2; m++) begin
            logic [15:0] ports [4];
            ports = '{16'h0CF9, 16'h0080, 16'h0CFD, 16'h0CF4};
            @(negedge clk) mode_translate = (m == 0);
            foreach (ports[k]) begin
                access(1'b1, 1'b0, ports[k], 4'h1, 32'hFFFF_FFFF, 4'h0, 1'b1, 3'd1,
                       {16'h0, ports[k]}, 32'h0, "R7 other port write");
                access(1'b0, 1'b0, ports[k], 4'hF, 32'h0, 4'h0, 1'b1, 3'd0,
                       {16'h0, ports[k]}, 32'h4000_0000 + k, "R7 other port read");
            end
        end
        @(negedge clk) mode_translate = 1'b1;
        cfg_read("R7 held address unchanged", 32'h3141_5926);

        // R8/R9: interrupt acknowledge for every ID, both modes
        for (int id = 0; id < 16; id++) begin
            logic [15:0] a;
            a = 16'h0A5C ^ 16'(id * 16'h1111);
            @(negedge clk) mode_translate = id[0];
            access(1'b0, 1'b1, a, 4'hF, 32'h0, 4'(id), 1'b1, 3'd6,
                   {16'h0, 4'(id), a[11:0]}, 32'h20 + id, "R8 R9 interrupt ack");
        end
        @(negedge clk) mode_translate = 1'b1;
        cfg_read("R9 no flush on plain read", 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule